// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves asynchronous smart card characters over a single open-drain I/O line in half duplex. Each character is a low start bit, eight data bits and one parity bit. Every bit lasts one elementary time unit (etu), which is a selectable number of base clock cycles. The host pushes a byte through a valid/ready handshake to send it, and it receives each decoded byte as a one-cycle strobe. Three configuration inputs set the character convention: the data bit order, the inversion of the data bits, and the parity sense. Setting the parity sense to odd with inverted data gives a parity level on the line that follows the even rule of the inverse convention.

In normal mode, a receiver that finds a parity error pulls the line low for one etu, late in the character, to ask for a repeat. A transmitter that sees the line low at that point records an error-signal flag. In block mode no error signal is driven or recorded, and the end-of-transmit flag rises earlier. The block drives the line low only. It releases the line for the high state, and the line idles high.

Top module: `sc_xcvr`

## Requirements
- R1: After reset the line is released (`line_pull_low`=0), `tx_ready`=1, `tx_end`=1, and `rx_valid`, `par_err` and `err_sig` are 0.
- R2: One etu is 32, 64, 372 or 256 base cycles for `etu_sel` = 0, 1, 2 or 3, and every transmitted bit holds its level for exactly one etu.
- R3: With `conv_msb_first`=0, `conv_data_inv`=0 and `parity_odd`=0, a sent byte appears on the line as a low start bit, then data bit 0 first up to bit 7, with 1 as released/high. It ends with a parity level equal to the XOR of the data bits, after which the line is released.
- R4: With `conv_msb_first`=1, `conv_data_inv`=1 and `parity_odd`=1, data bit 7 goes first and a data 1 is sent low. The parity level is the complement of the XOR of the data bits. For example, 0x3F is sent as low, high, high, six lows, high.
- R5: The receiver decodes both conventions with the same rules as R3 and R4. For each character, it gives one single-cycle `rx_valid` pulse with the byte on `rx_data`.
- R6: A low pulse shorter than half an etu, seen while idle, is rejected: no `rx_valid` follows.
- R7: A received parity mismatch sets the sticky `par_err`, which `flag_clr` clears. When a set and a clear fall in the same cycle, the set wins.
- R8: In normal mode, a receiver with a parity error pulls the line low for one etu, from about 10.5 to 11.5 etu after the start edge. It never does so for good parity or in block mode.
- R9: `tx_end` falls when a byte is accepted. It rises 11.5 etu after the start bit begins in block mode and 12.5 etu after in normal mode. `tx_ready` stays low while a character is being sent.
- R10: In normal mode, the transmitter sets the sticky `err_sig` if the line is low 11 etu after its start bit, and `flag_clr` clears it. In block mode `err_sig` reads 0.
- R11: The block is half duplex: `tx_ready` is low while a character is being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| etu_sel | input | 2 | Etu length select |
| conv_msb_first | input | 1 | Send and receive data bit 7 first |
| conv_data_inv | input | 1 | Invert the eight data bits on the line |
| parity_odd | input | 1 | Complement the parity level |
| block_mode | input | 1 | No error signalling, early transmit end |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Transmitter can accept a byte |
| tx_end | output | 1 | No transmission in progress |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| flag_clr | input | 1 | Clears `par_err` and `err_sig` |
| par_err | output | 1 | Sticky receive parity error |
| err_sig | output | 1 | Sticky error signal seen by the transmitter |
| line_in | input | 1 | Sensed level of the I/O line |
| line_pull_low | output | 1 | Pull the I/O line low |

## Verification
A parity error found at the receiver's parity sample and a host `flag_clr` can hit `par_err` in the same clock. The bench counts base cycles from the edge where it pulls the line low for a corrupted character. It then raises `flag_clr` for just the cycle in which the parity sample registers, the same cycle that carries `rx_valid`. After that cycle `par_err` must still read 1, and the scoreboard must see the byte together with its error bit.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int BIT_IDX_W = 4;

    typedef enum logic [0:0] {TX_IDLE, TX_SEND} tx_state_e;
    typedef enum logic [0:0] {RX_IDLE, RX_RECV} rx_state_e;

    typedef struct packed {
        logic msb_first;
        logic data_inv;
        logic par_odd;
        logic blk;
    } sc_mode_t;

    // data bit carried in time slot 1..8 of a character
    function automatic logic slot_bit(input logic [7:0] d,
                                      input logic [BIT_IDX_W-1:0] slot,
                                      input logic msb_first);
        logic [2:0] idx;
        idx = slot[2:0] - 3'd1;
        return msb_first ? d[3'd7 - idx] : d[idx];
    endfunction

    // line level expected in the parity slot
    function automatic logic par_level(input logic [7:0] d, input logic odd);
        return odd ^ (^d);
    endfunction

endpackage

// File: rtl/sc_bit_timer.sv
module sc_bit_timer #(
    parameter int CNT_W = 9
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           run,
    input  logic [CNT_W-1:0]               etu,
    output logic [CNT_W-1:0]               sub,
    output logic [sc_pkg::BIT_IDX_W-1:0]   slot
);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sub  <= '0;
            slot <= '0;
        end else if (sub == etu - ONE_C) begin
            sub  <= '0;
            slot <= slot + 1'b1;
        end else begin
            sub <= sub + ONE_C;
        end
    end
endmodule

// File: rtl/sc_tx.sv
module sc_tx
    import sc_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  sc_mode_t         mode,
    input  logic [CNT_W-1:0] etu,
    input  logic [CNT_W-1:0] half,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    input  logic             rx_busy,
    input  logic             line_s,
    output logic             tx_ready,
    output logic             tx_end,
    output logic             drive_low,
    output logic             ers_set
);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    tx_state_e               state;
    logic [7:0]              data_q;
    logic [CNT_W-1:0]        sub;
    logic [BIT_IDX_W-1:0]    slot;
    logic                    run;
    logic                    level;
    logic                    last;

    assign run = (state == TX_SEND);

    sc_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .etu  (etu),
        .sub  (sub),
        .slot (slot)
    );

    always_comb begin
        if (slot == 4'd0)
            level = 1'b0;
        else if (slot <= 4'd8)
            level = slot_bit(data_q, slot, mode.msb_first) ^ mode.data_inv;
        else if (slot == 4'd9)
            level = par_level(data_q, mode.par_odd);
        else
            level = 1'b1;
    end

    assign drive_low = run && (slot <= 4'd9) && !level;
    assign last      = (sub == half - ONE_C) &&
                       (mode.blk ? (slot == 4'd11) : (slot == 4'd12));
    assign tx_ready  = (state == TX_IDLE) && !rx_busy;
    assign ers_set   = run && !mode.blk && (slot == 4'd11) &&
                       (sub == '0) && !line_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            data_q <= '0;
            tx_end <= 1'b1;
        end else begin
            case (state)
                TX_IDLE: if (tx_valid && tx_ready) begin
                    state  <= TX_SEND;
                    data_q <= tx_data;
                    tx_end <= 1'b0;
                end
                TX_SEND: if (last) begin
                    state  <= TX_IDLE;
                    tx_end <= 1'b1;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sc_rx.sv
module sc_rx
    import sc_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  sc_mode_t         mode,
    input  logic [CNT_W-1:0] etu,
    input  logic [CNT_W-1:0] half,
    input  logic             enable,
    input  logic             line_s,
    output logic             busy,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             perr_set,
    output logic             drive_low
);
    rx_state_e               state;
    logic                    prev_q;
    logic [7:0]              shift_q;
    logic                    perr_pend;
    logic [CNT_W-1:0]        sub;
    logic [BIT_IDX_W-1:0]    slot;
    logic                    run;
    logic                    mid;
    logic                    start_det;
    logic                    bit_val;
    logic                    signalling;
    logic                    done;

    assign run       = (state == RX_RECV);
    assign busy      = run;
    assign mid       = run && (sub == half);
    assign start_det = (state == RX_IDLE) && enable && prev_q && !line_s;
    assign bit_val   = line_s ^ mode.data_inv;
    assign perr_set  = mid && (slot == 4'd9) &&
                       (line_s != par_level(shift_q, mode.par_odd));
    assign signalling = perr_pend && !mode.blk;
    assign drive_low = run && signalling &&
                       (((slot == 4'd10) && (sub >= half)) ||
                        ((slot == 4'd11) && (sub < half)));
    assign done      = mid && (((slot == 4'd10) && !signalling) ||
                               (slot == 4'd11));

    sc_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .etu  (etu),
        .sub  (sub),
        .slot (slot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_IDLE;
            prev_q    <= 1'b1;
            shift_q   <= '0;
            perr_pend <= 1'b0;
            rx_valid  <= 1'b0;
            rx_data   <= '0;
        end else begin
            prev_q   <= line_s;
            rx_valid <= 1'b0;
            case (state)
                RX_IDLE: if (start_det) begin
                    state     <= RX_RECV;
                    perr_pend <= 1'b0;
                end
                RX_RECV: begin
                    if (done) begin
                        state <= RX_IDLE;
                    end else if (mid) begin
                        if (slot == 4'd0) begin
                            if (line_s) state <= RX_IDLE;
                        end else if (slot <= 4'd8) begin
                            shift_q <= mode.msb_first ? {shift_q[6:0], bit_val}
                                                      : {bit_val, shift_q[7:1]};
                        end else if (slot == 4'd9) begin
                            rx_valid  <= 1'b1;
                            rx_data   <= shift_q;
                            perr_pend <= perr_set;
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sc_xcvr.sv
module sc_xcvr
    import sc_pkg::*;
#(
    parameter int ETU_SEL0    = 32,
    parameter int ETU_SEL1    = 64,
    parameter int ETU_SEL2    = 372,
    parameter int ETU_SEL3    = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] etu_sel,
    input  logic       conv_msb_first,
    input  logic       conv_data_inv,
    input  logic       parity_odd,
    input  logic       block_mode,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       tx_end,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    input  logic       flag_clr,
    output logic       par_err,
    output logic       err_sig,
    input  logic       line_in,
    output logic       line_pull_low
);
    localparam int MAX_A   = (ETU_SEL0 > ETU_SEL1) ? ETU_SEL0 : ETU_SEL1;
    localparam int MAX_B   = (ETU_SEL2 > ETU_SEL3) ? ETU_SEL2 : ETU_SEL3;
    localparam int ETU_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(ETU_MAX + 1);

    sc_mode_t               mode;
    logic [CNT_W-1:0]       etu;
    logic [CNT_W-1:0]       half;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line_s;
    logic                   tx_drive;
    logic                   rx_drive;
    logic                   rx_busy;
    logic                   perr_set;
    logic                   ers_set;
    logic                   ers_q;

    assign mode = '{msb_first: conv_msb_first, data_inv: conv_data_inv,
                    par_odd: parity_odd, blk: block_mode};

    always_comb begin
        case (etu_sel)
            2'd0:    etu = CNT_W'(ETU_SEL0);
            2'd1:    etu = CNT_W'(ETU_SEL1);
            2'd2:    etu = CNT_W'(ETU_SEL2);
            default: etu = CNT_W'(ETU_SEL3);
        endcase
    end
    assign half = etu >> 1;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= line_in;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            end
        end
    endgenerate
    assign line_s = sync_q[SYNC_STAGES-1];

    sc_tx #(.CNT_W(CNT_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .etu       (etu),
        .half      (half),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .rx_busy   (rx_busy),
        .line_s    (line_s),
        .tx_ready  (tx_ready),
        .tx_end    (tx_end),
        .drive_low (tx_drive),
        .ers_set   (ers_set)
    );

    sc_rx #(.CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .etu       (etu),
        .half      (half),
        .enable    (tx_end),
        .line_s    (line_s),
        .busy      (rx_busy),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .perr_set  (perr_set),
        .drive_low (rx_drive)
    );

    // sticky flags: a new event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            par_err <= 1'b0;
            ers_q   <= 1'b0;
        end else begin
            if (perr_set)      par_err <= 1'b1;
            else if (flag_clr) par_err <= 1'b0;
            if (ers_set)       ers_q <= 1'b1;
            else if (flag_clr) ers_q <= 1'b0;
        end
    end

    assign err_sig       = ers_q && !block_mode;
    assign line_pull_low = tx_drive || rx_drive;
endmodule

// File: rtl/sc_xcvr_chk.sv
module sc_xcvr_chk (
    input logic clk,
    input logic rst,
    input logic tx_ready,
    input logic tx_end,
    input logic rx_valid,
    input logic flag_clr,
    input logic par_err,
    input logic block_mode,
    input logic tx_drive,
    input logic rx_drive,
    input logic ers_q
);
    p_idle_release_r1: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> !tx_drive);

    p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_perr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (par_err && !flag_clr) |=> par_err);

    p_perr_with_byte_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(par_err) |-> rx_valid);

    p_block_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        block_mode |-> !rx_drive);

    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
        !tx_end |-> !tx_ready);

    p_ers_during_tx_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(ers_q) |-> !tx_end);

    p_half_duplex_r11: assert property (@(posedge clk) disable iff (rst)
        !(tx_drive && rx_drive));
endmodule

bind sc_xcvr sc_xcvr_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_ready   (tx_ready),
    .tx_end     (tx_end),
    .rx_valid   (rx_valid),
    .flag_clr   (flag_clr),
    .par_err    (par_err),
    .block_mode (block_mode),
    .tx_drive   (tx_drive),
    .rx_drive   (rx_drive),
    .ers_q      (ers_q)
);

// File: tb/sc_xcvr_test.sv
module sc_xcvr_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] etu_sel = 2'd0;
    logic       conv_msb_first = 1'b0;
    logic       conv_data_inv = 1'b0;
    logic       parity_odd = 1'b0;
    logic       block_mode = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready;
    logic       tx_end;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       flag_clr = 1'b0;
    logic       par_err;
    logic       err_sig;
    logic       line_pull_low;
    logic       card_low = 1'b0;
    logic       line;

    int checks = 0;
    int errors = 0;
    int rx_seen = 0;
    logic [8:0] exp_q[$];

    assign line = !(line_pull_low || card_low);

    always #2.5 clk = !clk;

    sc_xcvr uut (
        .clk            (clk),
        .rst            (rst),
        .etu_sel        (etu_sel),
        .conv_msb_first (conv_msb_first),
        .conv_data_inv  (conv_data_inv),
        .parity_odd     (parity_odd),
        .block_mode     (block_mode),
        .tx_valid       (tx_valid),
        .tx_data        (tx_data),
        .tx_ready       (tx_ready),
        .tx_end         (tx_end),
        .rx_valid       (rx_valid),
        .rx_data        (rx_data),
        .flag_clr       (flag_clr),
        .par_err        (par_err),
        .err_sig        (err_sig),
        .line_in        (line),
        .line_pull_low  (line_pull_low)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int etu_of(input logic [1:0] sel);
        case (sel)
            2'd0: return 32;
            2'd1: return 64;
            2'd2: return 372;
            default: return 256;
        endcase
    endfunction

    // line levels in time order: start, 8 data, parity
    function automatic logic [9:0] enc_levels(input logic [7:0] d, input logic inv,
                                              input logic badpar);
        logic [9:0] l;
        l[0] = 1'b0;
        for (int k = 0; k < 8; k++) l[k+1] = inv ? !d[7-k] : d[k];
        l[9] = (inv ? !(^d) : (^d)) ^ badpar;
        return l;
    endfunction

    task automatic set_cfg(input logic [1:0] sel, input logic inv, input logic blk);
        @(negedge clk);
        etu_sel = sel;
        conv_msb_first = inv;
        conv_data_inv = inv;
        parity_odd = inv;
        block_mode = blk;
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            rx_seen++;
            if (exp_q.size() == 0) begin
                chk("R6", "unexpected rx_valid", 1, 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk("R5", "rx_data", int'(rx_data), int'(e[7:0]));
                chk("R7", "par_err with byte", int'(par_err), int'(e[8]));
            end
        end
    end

    task automatic tx_frame(input string req, input logic [7:0] d, input logic card_err);
        int e;
        int h;
        int endoff;
        logic [9:0] lv;
        e = etu_of(etu_sel);
        h = e / 2;
        endoff = block_mode ? 11*e + h : 12*e + h;
        lv = enc_levels(d, conv_data_inv, 1'b0);
        @(negedge clk);
        chk("R9", "tx_ready before send", int'(tx_ready), 1);
        tx_valid = 1'b1;
        tx_data = d;
        @(negedge clk);
        tx_valid = 1'b0;
        for (int t = 0; t <= endoff; t++) begin
            if ((t % e) == h && (t / e) < 10)
                chk(req, $sformatf("tx slot %0d of %02h", t / e, d), int'(line), int'(lv[t/e]));
            if (t == 5) chk("R9", "tx_ready while sending", int'(tx_ready), 0);
            if (card_err && t == 10*e + h) card_low = 1'b1;
            if (card_err && t == 11*e + h) card_low = 1'b0;
            if (t == endoff - 1) chk("R9", "tx_end before end time", int'(tx_end), 0);
            if (t == endoff) chk("R9", "tx_end at end time", int'(tx_end), 1);
            if (t < endoff) @(negedge clk);
        end
        chk("R10", "err_sig after frame", int'(err_sig), int'(card_err && !block_mode));
    endtask

    // card side sends a character; called at a negedge
    task automatic card_send(input logic [7:0] d, input logic badpar);
        int e;
        logic [9:0] lv;
        e = etu_of(etu_sel);
        lv = enc_levels(d, conv_data_inv, badpar);
        exp_q.push_back({badpar, d});
        for (int i = 0; i < 10; i++) begin
            card_low = !lv[i];
            if (i == 5) begin
                @(negedge clk);
                chk("R11", "tx_ready while receiving", int'(tx_ready), 0);
                repeat (e - 1) @(negedge clk);
            end else begin
                repeat (e) @(negedge clk);
            end
        end
        card_low = 1'b0;
        repeat (e) @(negedge clk);
        chk("R8", "line at 11 etu", int'(line), int'(!(badpar && !block_mode)));
        repeat (e + e/2) @(negedge clk);
        chk("R8", "line released at 12.5 etu", int'(line), 1);
        repeat (e) @(negedge clk);
        chk("R5", "scoreboard drained", exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("WD", "watchdog expired", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "line released", int'(line_pull_low), 0);
        chk("R1", "tx_ready", int'(tx_ready), 1);
        chk("R1", "tx_end", int'(tx_end), 1);
        chk("R1", "rx_valid", int'(rx_valid), 0);
        chk("R1", "par_err", int'(par_err), 0);
        chk("R1", "err_sig", int'(err_sig), 0);

        // R3 direct transmit, normal mode
        set_cfg(2'd0, 1'b0, 1'b0);
        tx_frame("R3", 8'h3B, 1'b0);
        tx_frame("R3", 8'hA5, 1'b0);
        // R4 inverse transmit
        set_cfg(2'd0, 1'b1, 1'b0);
        tx_frame("R4", 8'h3F, 1'b0);
        tx_frame("R4", 8'h00, 1'b0);
        // R2 other etu lengths, block and normal end times
        set_cfg(2'd1, 1'b0, 1'b1);
        tx_frame("R2", 8'h96, 1'b0);
        set_cfg(2'd3, 1'b1, 1'b1);
        tx_frame("R2", 8'h5A, 1'b0);
        set_cfg(2'd2, 1'b0, 1'b0);
        tx_frame("R2", 8'hC3, 1'b0);

        // R10 error signal seen by the transmitter
        set_cfg(2'd0, 1'b0, 1'b0);
        tx_frame("R3", 8'h11, 1'b1);
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R10", "err_sig cleared", int'(err_sig), 0);
        set_cfg(2'd0, 1'b0, 1'b1);
        tx_frame("R3", 8'h22, 1'b1);

        // R5 reception, both conventions
        set_cfg(2'd0, 1'b0, 1'b0);
        card_send(8'h3B, 1'b0);
        card_send(8'h81, 1'b0);
        set_cfg(2'd0, 1'b1, 1'b0);
        card_send(8'h3F, 1'b0);

        // R8 / R7 parity error in normal and block modes
        set_cfg(2'd0, 1'b0, 1'b0);
        card_send(8'h6C, 1'b1);
        chk("R7", "par_err sticky", int'(par_err), 1);
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R7", "par_err cleared", int'(par_err), 0);
        set_cfg(2'd1, 1'b1, 1'b1);
        card_send(8'hE7, 1'b1);
        chk("R7", "par_err in block mode", int'(par_err), 1);
        chk("R10", "err_sig zero in block mode", int'(err_sig), 0);

        // R6 glitch rejection
        set_cfg(2'd0, 1'b0, 1'b0);
        begin
            int seen0;
            seen0 = rx_seen;
            card_low = 1'b1;
            repeat (5) @(negedge clk);
            card_low = 1'b0;
            repeat (12 * 32) @(negedge clk);
            chk("R6", "no byte after glitch", rx_seen, seen0);
        end
        card_send(8'h5D, 1'b0);

        // R7 set and clear in the same cycle
        set_cfg(2'd0, 1'b0, 1'b0);
        fork
            card_send(8'h47, 1'b1);
            begin
                repeat (3 + 9*32 + 16) @(negedge clk);
                flag_clr = 1'b1;
                @(negedge clk);
                flag_clr = 1'b0;
            end
        join
        chk("R7", "set wins over clear", int'(par_err), 1);

        // transmit still works after reception
        tx_frame("R3", 8'h3C, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule